// File: doc/BRIEF.md
# Transmit Packet Queue with Burst Ready Control

This block is the host-side write path of one port's transmit packet queue. An external bus master watches a single ready output and, when it is high, starts a write burst. It pushes one word per clock while an active-low select is held low and the port address matches this port's identity. Each word carries an end-of-packet flag. The drain side reads words and their flags through a valid/ready handshake.

Ready needs three things at once. Free space must exceed a programmed threshold. The number of complete packets held must be below a packet cap. No burst may be under way. The cap is small in normal mode and larger in multi-packet mode, so that a short frame queued between long ones does not stall the master. A burst stops once the number of words written equals the threshold, or on an end-of-packet word, whichever comes first. Ready is then judged again from the next cycle. The mode input takes effect only while the queue is empty.

Top module: `txq_ready_ctrl`

## Requirements
- R1: After reset the queue is empty, `rd_valid` and `ovf_err` are 0, and `host_rdy` is 1 whenever `thresh` is less than `DEPTH`.
- R2: Outside a burst, `host_rdy` is 1 exactly when (`DEPTH` minus stored words) is strictly greater than `thresh` and the complete-packet count is below the active cap.
- R3: In normal mode (`multi_req` = 0 while empty) the cap is `NORM_LIMIT` (default 2). `host_rdy` falls once that many packets are stored and rises again after the drain side reads one end-of-packet word.
- R4: In multi-packet mode (`multi_req` = 1 while empty) the cap is `MULTI_LIMIT` (default 16).
- R5: An accepted word that does not close a burst drives `host_rdy` low from the next cycle. The burst closes on the word whose index within the burst equals `thresh`, and `host_rdy` is judged again in the cycle after that word.
- R6: A word with `wr_eop` = 1 always closes the current burst, whatever its index.
- R7: A word is accepted only at a rising edge where `wr_sel_n` = 0 and `port_sel` equals `PORT_ID`. Any other cycle stores nothing.
- R8: A write while `DEPTH` words are stored is dropped, and `ovf_err` is 1 for exactly the following cycle.
- R9: The drain side sees words in write order with their end-of-packet flags. `rd_valid` is 1 whenever at least one word is stored. `rd_ready` while empty has no effect.
- R10: An end-of-packet word written in the same cycle as an end-of-packet word is read leaves the packet count unchanged.
- R11: `multi_req` is sampled into the active mode only on edges where the queue holds no words. A change while words are stored is ignored until the queue empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | $clog2(DEPTH+1) | Burst length limit and free-space threshold, 1..DEPTH |
| multi_req | input | 1 | Requested mode: 1 selects the multi-packet cap |
| port_sel | input | PORT_W | Port address driven by the master |
| wr_sel_n | input | 1 | Active-low write select |
| wr_data | input | DATA_W | Write word |
| wr_eop | input | 1 | Write word ends a packet |
| host_rdy | output | 1 | Master may begin a burst |
| ovf_err | output | 1 | A write was dropped on a full queue (one cycle, delayed) |
| rd_data | output | DATA_W | Head word |
| rd_eop | output | 1 | Head word ends a packet |
| rd_valid | output | 1 | Head word present |
| rd_ready | input | 1 | Drain side takes the head word |

## Verification
The bench aims at the exact edge where free space equals the threshold. A design that used greater-or-equal there would raise ready one word too early and allow a burst with no room for it. It stores exactly the cap number of packets, then reads one end-of-packet word. An off-by-one cap, or a packet count fed from the wrong side, would hold ready at the wrong level. It also writes and reads end-of-packet words in the same cycle, where a design that favoured one update would drift the count. It changes the mode while words are stored and writes one word past full. A design that switched mode at once would show the new cap too early. One that stored the extra word would hand back 33 words instead of 32.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef enum logic {
      TXQ_MODE_NORMAL = 1'b0,
      TXQ_MODE_MULTI  = 1'b1
   } txq_mode_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [DATA_W-1:0]          push_data,
   input  logic                       push_eop,
   input  logic                       pop,
   output logic [DATA_W-1:0]          head_data,
   output logic                       head_eop,
   output logic [$clog2(DEPTH+1)-1:0] occ
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [DATA_W:0] mem [DEPTH];
   logic [AW-1:0]   wp_q, rp_q, wp_nx, rp_nx;
   logic [CW-1:0]   occ_q;

   // pointer wrap: free-running for power-of-two depth, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= {push_eop, push_data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         occ_q <= '0;
      end else begin
         if (push) wp_q <= wp_nx;
         if (pop)  rp_q <= rp_nx;
         case ({push, pop})
            2'b10:   occ_q <= occ_q + 1'b1;
            2'b01:   occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end

   assign {head_eop, head_data} = mem[rp_q];
   assign occ = occ_q;

   a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= CW'(DEPTH));
   a_r9_pop_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (occ_q == $past(occ_q) - 1'b1));
endmodule

// File: rtl/txq_pkt_count.sv
module txq_pkt_count #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          eop_in,
   input  logic          eop_out,
   output logic [CW-1:0] pkts
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({eop_in, eop_out})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign pkts = cnt_q;

   a_r10_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eop_in && eop_out) |=> $stable(cnt_q));
   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      eop_out |-> (cnt_q != '0));
endmodule

// File: rtl/txq_burst.sv
module txq_burst #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          word_ok,
   input  logic          word_eop,
   input  logic [CW-1:0] thresh,
   output logic          in_burst
);
   logic          active_q;
   logic [CW-1:0] n_q, n_now;
   logic          closing;

   assign n_now   = active_q ? n_q + 1'b1 : CW'(1);
   assign closing = word_eop || (n_now >= thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         n_q      <= '0;
      end else if (word_ok) begin
         if (closing) begin
            active_q <= 1'b0;
            n_q      <= '0;
         end else begin
            active_q <= 1'b1;
            n_q      <= n_now;
         end
      end
   end

   assign in_burst = active_q;

   a_r5_len_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (n_q < thresh));
   a_r6_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (word_ok && word_eop) |=> !active_q);
endmodule

// File: rtl/txq_ready_ctrl.sv
module txq_ready_ctrl #(
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 256,
   parameter int PORT_W      = 2,
   parameter int PORT_ID     = 0,
   parameter int NORM_LIMIT  = 2,
   parameter int MULTI_LIMIT = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(DEPTH+1)-1:0] thresh,
   input  logic                       multi_req,
   input  logic [PORT_W-1:0]          port_sel,
   input  logic                       wr_sel_n,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       wr_eop,
   output logic                       host_rdy,
   output logic                       ovf_err,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       rd_eop,
   output logic                       rd_valid,
   input  logic                       rd_ready
);
   import txq_pkg::*;

   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txq_ready_ctrl: DEPTH must be at least 2");
      end
      if (NORM_LIMIT < 1 || MULTI_LIMIT < NORM_LIMIT || MULTI_LIMIT > DEPTH) begin : g_bad_limit
         $error("txq_ready_ctrl: need 1 <= NORM_LIMIT <= MULTI_LIMIT <= DEPTH");
      end
      if (PORT_ID >= (1 << PORT_W)) begin : g_bad_port
         $error("txq_ready_ctrl: PORT_ID does not fit PORT_W");
      end
   endgenerate

   logic          wr_hit, full, wr_ok, rd_take, in_burst;
   logic [CW-1:0] occ, pkts, free, cap;
   txq_mode_e     mode_q;
   logic          ovf_q;

   assign wr_hit  = !wr_sel_n && (port_sel == PORT_W'(PORT_ID));
   assign full    = (occ == CW'(DEPTH));
   assign wr_ok   = wr_hit && !full;
   assign rd_valid = (occ != '0);
   assign rd_take = rd_valid && rd_ready;

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
      .clk(clk), .rst_n(rst_n),
      .push(wr_ok), .push_data(wr_data), .push_eop(wr_eop),
      .pop(rd_take), .head_data(rd_data), .head_eop(rd_eop), .occ(occ)
   );

   txq_pkt_count #(.CW(CW)) i_pkts (
      .clk(clk), .rst_n(rst_n),
      .eop_in(wr_ok && wr_eop), .eop_out(rd_take && rd_eop), .pkts(pkts)
   );

   txq_burst #(.CW(CW)) i_burst (
      .clk(clk), .rst_n(rst_n),
      .word_ok(wr_ok), .word_eop(wr_eop), .thresh(thresh), .in_burst(in_burst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= TXQ_MODE_NORMAL;
         ovf_q  <= 1'b0;
      end else begin
         if (occ == '0) mode_q <= multi_req ? TXQ_MODE_MULTI : TXQ_MODE_NORMAL;
         ovf_q <= wr_hit && full;
      end
   end

   assign free     = CW'(DEPTH) - occ;
   assign cap      = (mode_q == TXQ_MODE_MULTI) ? CW'(MULTI_LIMIT) : CW'(NORM_LIMIT);
   assign host_rdy = !in_burst && (free > thresh) && (pkts < cap);
   assign ovf_err  = ovf_q;

   a_r2_thresh_range: assert property (@(posedge clk) disable iff (!rst_n)
      thresh <= CW'(DEPTH));
   a_r2_rdy_not_full: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdy |-> !full);
   a_r8_ovf_after_full: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |-> ($past(occ) == CW'(DEPTH)));
   a_r11_mode_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> ($past(occ) == '0));
   a_r10_pkts_within_words: assert property (@(posedge clk) disable iff (!rst_n)
      pkts <= occ);
endmodule

// File: tb/test_txq_ready_ctrl.sv
module test_txq_ready_ctrl;
   localparam int DW = 8;
   localparam int DEPTH = 32;
   localparam int CW = $clog2(DEPTH+1);
   localparam int NCAP = 2;
   localparam int MCAP = 16;

   logic clk = 0, rst_n = 0;
   logic [CW-1:0] thresh = CW'(4);
   logic multi_req = 0, wr_sel_n = 1, wr_eop = 0, rd_ready = 0;
   logic [0:0] port_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic host_rdy, ovf_err, rd_eop, rd_valid;
   logic [DW-1:0] rd_data;

   txq_ready_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .PORT_W(1), .PORT_ID(0),
      .NORM_LIMIT(NCAP), .MULTI_LIMIT(MCAP)) i_txq_ready_ctrl (
      .clk(clk), .rst_n(rst_n), .thresh(thresh), .multi_req(multi_req),
      .port_sel(port_sel), .wr_sel_n(wr_sel_n), .wr_data(wr_data), .wr_eop(wr_eop),
      .host_rdy(host_rdy), .ovf_err(ovf_err), .rd_data(rd_data), .rd_eop(rd_eop),
      .rd_valid(rd_valid), .rd_ready(rd_ready));

   always #2 clk = ~clk;

   int total = 0, bad = 0, cyc = 0;
   bit auto_drain = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference queue model, updated from the requirements at each edge
   logic [DW:0] q[$];
   int m_pk = 0, m_bw = 0;
   bit m_burst = 0, m_mode = 0, m_ovf = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         q.delete(); m_pk = 0; m_bw = 0; m_burst = 0; m_mode = 0; m_ovf = 0;
      end else begin
         bit wr, wok, rd; int n;
         wr  = !wr_sel_n && port_sel == 1'b0;
         wok = wr && q.size() < DEPTH;
         rd  = q.size() > 0 && rd_ready;
         m_ovf = wr && !wok;
         if (q.size() == 0) m_mode = multi_req;
         if (rd) begin
            if (q[0][DW]) m_pk--;
            void'(q.pop_front());
         end
         if (wok) begin
            q.push_back({wr_eop, wr_data});
            if (wr_eop) m_pk++;
            n = m_burst ? m_bw + 1 : 1;
            if (wr_eop || n >= int'(thresh)) begin m_burst = 0; m_bw = 0; end
            else begin m_burst = 1; m_bw = n; end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit er;
         er = !m_burst && (DEPTH - q.size()) > int'(thresh) && m_pk < (m_mode ? MCAP : NCAP);
         chk("R2 ready vs model", host_rdy, er);
         chk("R8 ovf vs model", ovf_err, m_ovf);
         chk("R9 valid vs model", rd_valid, q.size() > 0);
         if (q.size() > 0) chk("R9 head vs model", {rd_eop, rd_data}, q[0]);
      end
      if (auto_drain) rd_ready = (cyc % 3 != 2);
   end

   initial begin
      #600000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic put(logic [DW-1:0] d, logic e);
      @(negedge clk); wr_sel_n = 0; port_sel = 1'b0; wr_data = d; wr_eop = e;
   endtask
   task automatic idle(int n);
      repeat (n) begin @(negedge clk); wr_sel_n = 1; wr_eop = 0; end
   endtask
   task automatic drain(int n);
      repeat (n) begin @(negedge clk); wr_sel_n = 1; rd_ready = 1; end
      @(negedge clk); rd_ready = 0;
   endtask

   task automatic send_pkt(int len, int thr, int tagv);
      int k = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         while (k == 0 && !host_rdy) begin wr_sel_n = 1; @(negedge clk); end
         wr_sel_n = 0; port_sel = 1'b0; wr_data = DW'(tagv + i); wr_eop = (i == len - 1);
         k++;
         if (k == thr || i == len - 1) k = 0;
      end
      idle(1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 ready after reset", host_rdy, 1);
      chk("R1 valid after reset", rd_valid, 0);
      chk("R1 ovf after reset", ovf_err, 0);

      // R5/R6/R3 in normal mode, thresh 4
      put(8'h10, 0); put(8'h11, 0); #1;
      chk("R5 ready low inside burst", host_rdy, 0);
      put(8'h12, 0); put(8'h13, 0); idle(1); #1;
      chk("R5 burst closes at thresh", host_rdy, 1);
      put(8'h14, 1); idle(1); #1;
      chk("R6 eop word closes burst", host_rdy, 1);
      put(8'h20, 0); put(8'h21, 1); idle(1); #1;
      chk("R3 two packets drop ready", host_rdy, 0);
      drain(5); #1;
      chk("R3 one eop read restores ready", host_rdy, 1);
      drain(2); #1;
      chk("R9 empty after drain", rd_valid, 0);

      // R9 read of empty ignored
      drain(3);
      put(8'h5A, 1); idle(1); #1;
      chk("R9 valid after empty read", rd_valid, 1);
      chk("R9 data after empty read", rd_data, 8'h5A);
      drain(1); #1;
      chk("R9 empty again", rd_valid, 0);

      // R7 foreign port and deselected cycles
      @(negedge clk); wr_sel_n = 0; port_sel = 1'b1; wr_data = 8'h77; wr_eop = 1;
      @(negedge clk); wr_sel_n = 1; port_sel = 1'b0;
      idle(1); #1;
      chk("R7 no store", rd_valid, 0);

      // R4 and R11
      multi_req = 1; idle(2);
      for (int i = 0; i < 15; i++) put(DW'(i), 1);
      idle(1); #1;
      chk("R4 fifteen packets ready", host_rdy, 1);
      put(8'h0F, 1); idle(1); #1;
      chk("R4 sixteen packets stop", host_rdy, 0);
      multi_req = 0;
      drain(1); #1;
      chk("R11 mode held while not empty", host_rdy, 1);
      drain(15); idle(1);
      put(8'hA0, 1); put(8'hA1, 1); idle(1); #1;
      chk("R11 normal cap after empty", host_rdy, 0);
      drain(2);

      // R10 simultaneous eop in and out
      put(8'hB0, 1); idle(1);
      @(negedge clk); wr_sel_n = 0; wr_data = 8'hB1; wr_eop = 1; rd_ready = 1;
      @(negedge clk); wr_sel_n = 1; rd_ready = 0; #1;
      chk("R10 count unchanged", host_rdy, 1);
      put(8'hB2, 1); idle(1); #1;
      chk("R10 second packet reaches cap", host_rdy, 0);
      drain(2);

      // R2 threshold edge and R8 overflow
      for (int i = 0; i < 24; i++) put(DW'(i), 0);
      idle(1); #1;
      chk("R2 free 8 above thresh 4", host_rdy, 1);
      for (int i = 24; i < 28; i++) put(DW'(i), 0);
      idle(1); #1;
      chk("R2 free equal thresh", host_rdy, 0);
      for (int i = 28; i < 32; i++) put(DW'(i), 0);
      put(8'hEE, 0); idle(1); #1;
      chk("R8 ovf flagged", ovf_err, 1);
      idle(1); #1;
      chk("R8 ovf one cycle", ovf_err, 0);
      drain(32); #1;
      chk("R8 extra word dropped", rd_valid, 0);

      // sweep thresholds, lengths and modes with concurrent drain
      auto_drain = 1;
      for (int t = 1; t <= 5; t++) begin
         thresh = CW'(t);
         multi_req = t[0];
         for (int len = 1; len <= 7; len++) send_pkt(len, t, t * 16 + len);
      end
      idle(40);
      auto_drain = 0; rd_ready = 0;
      idle(2); #1;
      chk("R9 sweep drained", rd_valid, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule